// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block drives the frequency-modulation profile of a fractional-N clock synthesizer. On every update tick it produces a signed deviation word that follows a triangular sweep. The sweep runs from the lowest frequency point up to the highest and back down. The synthesizer adds this word to its nominal feedback divide value. The block also presents the sum of the nominal divide and the current deviation, so the sum can feed the divider directly.

Two spread shapes are offered. In center spread the deviation swings equally on both sides of zero, so the mean frequency stays on target. In down spread the deviation only ever lowers the divide, so the peak frequency equals the target and the mean sits below it. The spread amount is a count of 0.125 % steps. A rate-select bit chooses between two programmed half-period lengths (in ticks), one sized for the roughly 32 kHz rate and one for the 120 kHz rate.

The deviation unit is 1/H of a 0.0625 % step, where H is the active half-period length in ticks. With that unit, the total swing of the deviation equals the amount code times 0.125 %. New settings are taken only when a sweep period begins, so no sweep mixes two configurations.

Top module: `ssm_triangle_gen`

## Requirements
- R1: After reset, `dev` is 0 and `mod_div` equals `nom_div`.
- R2: A tick with `en` low forces `dev` to 0 and parks the sweep. The first tick with `en` high after that outputs the minimum point of a new period (position 0).
- R3: The amount code A is clamped per mode. In center mode (`down_mode`=0) A is clamped to 1..16. In down mode (`down_mode`=1) A is clamped to 2..32.
- R4: In center mode, `dev` = A·(2p − H) at triangle position p. The peaks are −A·H and +A·H, and the sum over a whole period is 0.
- R5: In down mode, `dev` = −2·A·p. `dev` is never positive, its extremes are 0 and −2·A·H, and its mean over a whole period is −A·H.
- R6: Within a period the position takes the values 0,1,…,H,H−1,…,1. A period is exactly 2·H ticks, and no extreme value is repeated or skipped. Consecutive samples inside a period therefore differ by exactly 2·A.
- R7: H is `fast_half` when `rate_fast`=1 and `slow_half` when `rate_fast`=0. A value of 0 is treated as 1.
- R8: `down_mode`, the amount code and H are sampled only on the tick that begins a period, either a period wrap or the first enabled tick. Changes made in mid-period take no effect until the next period.
- R9: `dev` changes only on cycles where `tick` is high.
- R10: `mod_div` equals `nom_div` plus the sign-extended `dev`, taken modulo 2^DIV_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Update strobe; one profile step per high cycle |
| en | input | 1 | Modulation enable |
| down_mode | input | 1 | 0 = center spread, 1 = down spread |
| amt_code | input | CODE_W | Spread amount in 0.125 % steps |
| rate_fast | input | 1 | 0 = slow rate (slow_half), 1 = fast rate (fast_half) |
| slow_half | input | HALF_W | Ticks per half period at the slow rate |
| fast_half | input | HALF_W | Ticks per half period at the fast rate |
| nom_div | input | DIV_W | Nominal fractional feedback divide |
| dev | output | DEV_W | Signed deviation word (DEV_W = HALF_W+CODE_W+2) |
| mod_div | output | DIV_W | nom_div + dev |

## Verification
The assertions check the following on every cycle:
- `dev` holds steady between ticks.
- A disabled tick yields zero.
- Down spread never goes positive.
- Center spread stays inside ±A·H.
- The clamped amount stays in its legal band.
- Each in-period step has magnitude exactly 2·A.

Other properties need a reference to compare against, so only the directed scenarios can show them. These are the exact shape of each sweep, the period length for each rate, the mean over whole periods, the clamp values for out-of-range codes, the deferred take-up of settings changed in mid-period, and restart at the minimum point after a disable.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    // legal amount bands, in 0.125 % steps
    localparam int CTR_AMT_MIN = 1;
    localparam int CTR_AMT_MAX = 16;
    localparam int DN_AMT_MIN  = 2;
    localparam int DN_AMT_MAX  = 32;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_e;
endpackage

// File: rtl/ssm_cfg_sat.sv
// Clamps the amount code to the band of the selected mode and picks the
// half-period length for the selected rate.
module ssm_cfg_sat
    import ssm_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int HALF_W = 12
) (
    input  logic              down_mode,
    input  logic [CODE_W-1:0] amt_code,
    input  logic              rate_fast,
    input  logic [HALF_W-1:0] slow_half,
    input  logic [HALF_W-1:0] fast_half,
    output logic [CODE_W-1:0] amt,
    output logic [HALF_W-1:0] half
);
    logic [CODE_W-1:0] lo, hi;
    logic [HALF_W-1:0] half_raw;

    always_comb begin
        lo = (spread_e'(down_mode) == SPREAD_DOWN) ? CODE_W'(DN_AMT_MIN) : CODE_W'(CTR_AMT_MIN);
        hi = (spread_e'(down_mode) == SPREAD_DOWN) ? CODE_W'(DN_AMT_MAX) : CODE_W'(CTR_AMT_MAX);
        if (amt_code < lo)      amt = lo;
        else if (amt_code > hi) amt = hi;
        else                    amt = amt_code;

        half_raw = rate_fast ? fast_half : slow_half;
        half     = (half_raw == '0) ? HALF_W'(1) : half_raw;
    end
endmodule

// File: rtl/ssm_tri_phase.sv
// Maps a period counter (0 .. 2H-1) onto a triangle position and flags the
// last count of the period.
module ssm_tri_phase #(
    parameter int HALF_W = 12,
    localparam int CNT_W = HALF_W + 1
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [HALF_W-1:0] half,
    output logic [HALF_W-1:0] pos,
    output logic              last,
    output logic [CNT_W-1:0]  cnt_inc
);
    logic [CNT_W-1:0] h_ext, twice;

    always_comb begin
        h_ext   = {1'b0, half};
        twice   = {half, 1'b0};
        pos     = (cnt <= h_ext) ? cnt[HALF_W-1:0] : HALF_W'(twice - cnt);
        last    = (cnt == twice - CNT_W'(1));
        cnt_inc = cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ssm_dev_map.sv
// Scales a triangle position into the signed deviation word for the mode.
module ssm_dev_map
    import ssm_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int HALF_W = 12,
    parameter int DEV_W  = HALF_W + CODE_W + 2
) (
    input  logic                    down_mode,
    input  logic [CODE_W-1:0]       amt,
    input  logic [HALF_W-1:0]       half,
    input  logic [HALF_W-1:0]       pos,
    output logic signed [DEV_W-1:0] dev
);
    logic signed [DEV_W-1:0] a_s, p_s, h_s;

    always_comb begin
        a_s = DEV_W'(amt);
        p_s = DEV_W'(pos);
        h_s = DEV_W'(half);
        if (spread_e'(down_mode) == SPREAD_DOWN)
            dev = -(a_s * (p_s + p_s));
        else
            dev = a_s * (p_s + p_s - h_s);
    end
endmodule

// File: rtl/ssm_triangle_gen.sv
module ssm_triangle_gen
    import ssm_pkg::*;
#(
    parameter  int CODE_W = 6,
    parameter  int HALF_W = 12,
    parameter  int DIV_W  = 24,
    localparam int DEV_W  = HALF_W + CODE_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    en,
    input  logic                    down_mode,
    input  logic [CODE_W-1:0]       amt_code,
    input  logic                    rate_fast,
    input  logic [HALF_W-1:0]       slow_half,
    input  logic [HALF_W-1:0]       fast_half,
    input  logic [DIV_W-1:0]        nom_div,
    output logic signed [DEV_W-1:0] dev,
    output logic [DIV_W-1:0]        mod_div
);
    localparam int CNT_W = HALF_W + 1;

    typedef struct packed {
        logic                    run;
        logic [CNT_W-1:0]        cnt;
        logic                    down;
        logic [CODE_W-1:0]       amt;
        logic [HALF_W-1:0]       half;
        logic signed [DEV_W-1:0] dev;
    } gen_st_t;

    gen_st_t st_d, st_q;

    // settings offered at the port, already clamped
    logic [CODE_W-1:0] sat_amt;
    logic [HALF_W-1:0] sat_half;

    ssm_cfg_sat #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_sat (
        .down_mode (down_mode),
        .amt_code  (amt_code),
        .rate_fast (rate_fast),
        .slow_half (slow_half),
        .fast_half (fast_half),
        .amt       (sat_amt),
        .half      (sat_half)
    );

    // where the current period stands
    logic [HALF_W-1:0] pos_cur_unused;
    logic              last_q;
    logic [CNT_W-1:0]  cnt_inc;

    ssm_tri_phase #(.HALF_W(HALF_W)) u_ph_cur (
        .cnt     (st_q.cnt),
        .half    (st_q.half),
        .pos     (pos_cur_unused),
        .last    (last_q),
        .cnt_inc (cnt_inc)
    );

    // a period begins on the first enabled tick or after the last count
    logic              reload;
    logic [CNT_W-1:0]  cnt_n;
    logic              down_n;
    logic [CODE_W-1:0] amt_n;
    logic [HALF_W-1:0] half_n;

    assign reload = !st_q.run || last_q;
    assign cnt_n  = reload ? '0 : cnt_inc;
    assign down_n = reload ? down_mode : st_q.down;
    assign amt_n  = reload ? sat_amt   : st_q.amt;
    assign half_n = reload ? sat_half  : st_q.half;

    logic [HALF_W-1:0] pos_n;
    logic              last_n_unused;
    logic [CNT_W-1:0]  inc_n_unused;

    ssm_tri_phase #(.HALF_W(HALF_W)) u_ph_nxt (
        .cnt     (cnt_n),
        .half    (half_n),
        .pos     (pos_n),
        .last    (last_n_unused),
        .cnt_inc (inc_n_unused)
    );

    logic signed [DEV_W-1:0] dev_n;

    ssm_dev_map #(.CODE_W(CODE_W), .HALF_W(HALF_W), .DEV_W(DEV_W)) u_map (
        .down_mode (down_n),
        .amt       (amt_n),
        .half      (half_n),
        .pos       (pos_n),
        .dev       (dev_n)
    );

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (!en) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
                st_d.dev = '0;
            end else begin
                st_d.run  = 1'b1;
                st_d.cnt  = cnt_n;
                st_d.down = down_n;
                st_d.amt  = amt_n;
                st_d.half = half_n;
                st_d.dev  = dev_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= HALF_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign dev     = st_q.dev;
    assign mod_div = nom_div + {{(DIV_W-DEV_W){st_q.dev[DEV_W-1]}}, st_q.dev};

    // ---------------- assertions ----------------
    logic signed [DEV_W-1:0] bound_s, step_s;
    assign bound_s = DEV_W'(st_q.amt) * DEV_W'(st_q.half);
    assign step_s  = DEV_W'(st_q.amt) + DEV_W'(st_q.amt);

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dev)) else $error("dev moved without tick"); // R9

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !en |=> dev == '0) else $error("disabled tick not zero"); // R2

    AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.down |-> st_q.dev <= 0) else $error("down spread above target"); // R5

    AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.down |-> (st_q.dev <= bound_s) && (st_q.dev >= -bound_s))
        else $error("center spread beyond amount"); // R4

    AST_AMT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.down ? (st_q.amt >= CODE_W'(DN_AMT_MIN) && st_q.amt <= CODE_W'(DN_AMT_MAX))
                                : (st_q.amt >= CODE_W'(CTR_AMT_MIN) && st_q.amt <= CODE_W'(CTR_AMT_MAX))))
        else $error("amount outside band"); // R3

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        tick && en && st_q.run && !last_q |=>
            (dev - $past(dev) == step_s) || ($past(dev) - dev == step_s))
        else $error("in-period step not 2A"); // R6
endmodule

// File: tb/sim_ssm_triangle_gen.sv
module sim_ssm_triangle_gen;
    localparam int CLK_P  = 10;
    localparam int CODE_W = 6;
    localparam int HALF_W = 12;
    localparam int DIV_W  = 24;
    localparam int DEV_W  = HALF_W + CODE_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, en = 1'b0, down_mode = 1'b0, rate_fast = 1'b0;
    logic [CODE_W-1:0] amt_code = '0;
    logic [HALF_W-1:0] slow_half = '0, fast_half = '0;
    logic [DIV_W-1:0]  nom_div = 24'h400000;
    logic signed [DEV_W-1:0] dev;
    logic [DIV_W-1:0] mod_div;

    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ssm_triangle_gen #(.CODE_W(CODE_W), .HALF_W(HALF_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .down_mode(down_mode),
        .amt_code(amt_code), .rate_fast(rate_fast), .slow_half(slow_half),
        .fast_half(fast_half), .nom_div(nom_div), .dev(dev), .mod_div(mod_div)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_dev(bit dn, int a, int h, int k);
        int kk = k % (2*h);
        int p  = (kk <= h) ? kk : 2*h - kk;
        return dn ? -2*a*p : a*(2*p - h);
    endfunction

    // one update strobe; outputs are settled at the returning negedge
    task automatic step();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic begin_run(bit dn, int code, bit fast, int slow, int fst);
        en = 1'b0;
        step();
        down_mode = dn; amt_code = CODE_W'(code); rate_fast = fast;
        slow_half = HALF_W'(slow); fast_half = HALF_W'(fst);
        en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 dev", int'(dev), 0);
        chk("R1/R10 mod_div", int'(mod_div), int'(nom_div));
    endtask

    // two whole periods, checking each sample, peaks and the sum
    task automatic t_sweep(string req, bit dn, int code, bit fast, int slow, int fst,
                           int a, int h);
        int sum = 0, mx = -(1<<30), mn = (1<<30);
        begin_run(dn, code, fast, slow, fst);
        for (int k = 0; k < 4*h; k++) begin
            step();
            chk(req, int'(dev), exp_dev(dn, a, h, k));
            sum += int'(dev);
            if (int'(dev) > mx) mx = int'(dev);
            if (int'(dev) < mn) mn = int'(dev);
        end
        chk({req, " R6 max"}, mx, dn ? 0 : a*h);
        chk({req, " R6 min"}, mn, dn ? -2*a*h : -a*h);
        chk({req, " mean sum"}, sum, dn ? -a*h*4*h : 0);
        chk("R10 mod_div", int'(mod_div), (int'(nom_div) + int'(dev)) & 24'hFFFFFF);
    endtask

    task automatic t_hold_disable();
        begin_run(1'b0, 3, 1'b0, 3, 7);
        for (int k = 0; k < 3; k++) step();
        chk("R9 pre-hold", int'(dev), 3);
        repeat (3) @(negedge clk);
        chk("R9 held", int'(dev), 3);
        en = 1'b0;
        step();
        chk("R2 off", int'(dev), 0);
        step();
        chk("R2 stays off", int'(dev), 0);
        en = 1'b1;
        step();
        chk("R2 restart min", int'(dev), -9);
        step();
        chk("R2 restart next", int'(dev), -3);
    endtask

    task automatic t_latch();
        begin_run(1'b0, 4, 1'b0, 4, 7);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 pre", int'(dev), exp_dev(1'b0, 4, 4, k));
        end
        down_mode = 1'b1; amt_code = 6'd10; slow_half = 12'd2;
        for (int k = 3; k < 8; k++) begin
            step();
            chk("R8 old cfg kept", int'(dev), exp_dev(1'b0, 4, 4, k));
        end
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R8 new cfg", int'(dev), exp_dev(1'b1, 10, 2, k));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep("R4 center A4 slow", 1'b0, 4, 1'b0, 5, 2, 4, 5);
        t_sweep("R5 down A8 fast R7", 1'b1, 8, 1'b1, 6, 3, 8, 3);
        t_sweep("R3 center code0", 1'b0, 0, 1'b0, 2, 9, 1, 2);
        t_sweep("R3 center code40", 1'b0, 40, 1'b1, 9, 2, 16, 2);
        t_sweep("R3 down code1", 1'b1, 1, 1'b0, 3, 9, 2, 3);
        t_sweep("R3 down code63", 1'b1, 63, 1'b1, 9, 4, 32, 4);
        t_sweep("R7 half zero", 1'b0, 2, 1'b0, 0, 5, 2, 1);
        t_hold_disable();
        t_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule